// File: doc/BRIEF.md
# Asynchronous Exception Routing Unit

This block decides, for a processor with four privilege levels (0 to 3), which pending asynchronous event is taken next and at which level it is taken. It watches six pending lines: three physical sources (system error, fast interrupt, normal interrupt) and three virtual ones of the same kinds. From the current level, the implemented or enabled higher levels and the routing control bits, it computes a target level for each candidate. It then grants the candidate with the highest priority.

One cycle after a request is seen, a single-cycle take pulse is issued together with the target level, the vector offset, the event kind, a virtual flag, a 25-bit syndrome and the return address. For system errors it also issues a strobe that clears the matching pending flag. Masking, vector fetch and state save belong to the surrounding core. Parameter `HAS_RELIAB` selects whether a virtual system error takes its syndrome from a hypervisor-programmed register (1) or from the syndrome inputs (0).

Top module: `async_exc_router`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero at that edge.
- R2: A physical fast interrupt targets level 3 when `lvl3_present` and `rt3_fiq` are both set. Otherwise it targets level 2 if `cur_lvl` is 2, or if `cur_lvl` is 0 or 1 with `lvl2_active` set and either `trap_gen` or `ovr_fiq` set. Otherwise it targets level 1.
- R3: A physical normal interrupt follows the R2 rule, using `rt3_irq` in place of `rt3_fiq` and `ovr_irq` in place of `ovr_fiq`. `ovr_fiq` has no effect on it.
- R4: A physical system error targets level 3 when `cur_lvl` is 3, or when `lvl3_present` and `rt3_abort` are both set. Otherwise it targets level 2 if `cur_lvl` is 2, or if `cur_lvl` is 0 or 1 with `lvl2_active` set and either `trap_gen` set or `ovr_abort` set with `host_mode` clear. Otherwise it targets level 1.
- R5: A physical fast or normal interrupt taken while `cur_lvl` is 3 is never delivered to level 2. When its level-3 route bit is clear, it is delivered to level 3.
- R6: `exc_kind_o` is encoded as 1 for a normal interrupt, 2 for a fast interrupt and 3 for a system error. `vec_off_o` is 0x080, 0x100 and 0x180 for these kinds, and the same offsets apply to virtual sources. `virt_o` is 1 only for a virtual source.
- R7: For a physical system error, syndrome bit 24 equals `serr_flag` and bits 23:0 equal `serr_synd`. For fast and normal interrupts the syndrome is zero.
- R8: A virtual source is accepted only when `cur_lvl` is 0 or 1, `lvl2_active` is set, `trap_gen` is clear and its own override bit is set. An accepted virtual source always targets level 1. A virtual source that fails this test produces no take pulse and no clear strobe.
- R9: With `HAS_RELIAB`=1, a virtual system error takes syndrome bit 24 from `vsyn_flag` and bits 23:0 from `vsyn_val`. With `HAS_RELIAB`=0, bit 24 is `serr_flag` and bits 23:0 are `serr_synd` if that flag is set, otherwise zero.
- R10: `clr_phys_serr_o` pulses exactly when a physical system error is taken, and `clr_virt_serr_o` pulses exactly when a virtual system error is taken. The two never pulse together.
- R11: When several sources are eligible in the same cycle, the block grants them in this fixed order: physical system error, physical fast, physical normal, virtual system error, virtual fast, virtual normal. It takes one event per cycle.
- R12: All outputs are registered. A request seen at one clock edge is reported at that edge with `take_o` high and `ret_addr_o` equal to `cur_pc`. `take_o` is low in any cycle that follows an edge with no eligible request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_phys_serr | input | 1 | Physical system error pending |
| pend_phys_fiq | input | 1 | Physical fast interrupt pending |
| pend_phys_irq | input | 1 | Physical normal interrupt pending |
| pend_virt_serr | input | 1 | Virtual system error pending |
| pend_virt_fiq | input | 1 | Virtual fast interrupt pending |
| pend_virt_irq | input | 1 | Virtual normal interrupt pending |
| cur_lvl | input | 2 | Current privilege level |
| lvl3_present | input | 1 | Level 3 is implemented |
| lvl2_active | input | 1 | Level 2 is enabled |
| rt3_fiq | input | 1 | Route fast interrupts to level 3 |
| rt3_irq | input | 1 | Route normal interrupts to level 3 |
| rt3_abort | input | 1 | Route system errors to level 3 |
| trap_gen | input | 1 | General trap-to-level-2 control |
| ovr_fiq | input | 1 | Fast interrupt override to level 2 |
| ovr_irq | input | 1 | Normal interrupt override to level 2 |
| ovr_abort | input | 1 | System error override to level 2 |
| host_mode | input | 1 | Host mode active at level 2 |
| serr_flag | input | 1 | Implementation-defined syndrome flag |
| serr_synd | input | 24 | System error syndrome value |
| vsyn_flag | input | 1 | Hypervisor-programmed virtual syndrome flag |
| vsyn_val | input | 24 | Hypervisor-programmed virtual syndrome value |
| cur_pc | input | ADDR_W | Address of the current instruction |
| take_o | output | 1 | Take-exception pulse |
| tgt_lvl_o | output | 2 | Target level |
| vec_off_o | output | 12 | Vector offset |
| exc_kind_o | output | 2 | Event kind (1 normal, 2 fast, 3 system error) |
| virt_o | output | 1 | Taken source is virtual |
| synd_o | output | 25 | Syndrome |
| ret_addr_o | output | ADDR_W | Preferred return address |
| clr_phys_serr_o | output | 1 | Clear physical system error pending |
| clr_virt_serr_o | output | 1 | Clear virtual system error pending |

## Verification
The block holds no state beyond its output register. A wrong routing term or a wrong priority link therefore appears at the ports on the edge that follows the offending input pattern, as a wrong target level, kind or clear strobe. The bench sets each routing bit on its own, and also pairs bits that interact, such as host mode with the abort override and the trap bit with the virtual gates. A term that reads the wrong control bit then changes the level seen in the very next cycle. Stuck strobes or a take pulse that fails to drop show up one cycle after the pending lines are released.

// File: rtl/aer_pkg.sv
package aer_pkg;
  localparam int NSRC  = 6;
  localparam int SYN_W = 24;
  localparam int OFF_W = 12;

  localparam int S_PSERR = 0;
  localparam int S_PFIQ  = 1;
  localparam int S_PIRQ  = 2;
  localparam int S_VSERR = 3;
  localparam int S_VFIQ  = 4;
  localparam int S_VIRQ  = 5;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_IRQ  = 2'd1,
    K_FIQ  = 2'd2,
    K_SERR = 2'd3
  } kind_t;

  typedef struct packed {
    kind_t      kind;
    logic       virt;
    logic [1:0] tgt;
  } desc_t;

  function automatic logic [OFF_W-1:0] vec_of(kind_t k);
    case (k)
      K_IRQ:   return OFF_W'(12'h080);
      K_FIQ:   return OFF_W'(12'h100);
      K_SERR:  return OFF_W'(12'h180);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/aer_route.sv
module aer_route (
  input  logic [1:0] cur_lvl,
  input  logic       lvl3_present,
  input  logic       lvl2_active,
  input  logic       rt3_fiq,
  input  logic       rt3_irq,
  input  logic       rt3_abort,
  input  logic       trap_gen,
  input  logic       ovr_fiq,
  input  logic       ovr_irq,
  input  logic       ovr_abort,
  input  logic       host_mode,
  output logic [1:0] tgt_pfiq,
  output logic [1:0] tgt_pirq,
  output logic [1:0] tgt_pserr,
  output logic       ok_vserr,
  output logic       ok_vfiq,
  output logic       ok_virq
);
  logic low_lvl;
  logic at_l2;
  logic at_l3;
  logic l2_fiq, l2_irq, l2_serr;
  logic guest_gate;

  assign low_lvl = (cur_lvl == 2'd0) || (cur_lvl == 2'd1);
  assign at_l2   = (cur_lvl == 2'd2);
  assign at_l3   = (cur_lvl == 2'd3);

  // level-2 capture terms for physical sources taken below level 2
  assign l2_fiq  = low_lvl && lvl2_active && (trap_gen || ovr_fiq);
  assign l2_irq  = low_lvl && lvl2_active && (trap_gen || ovr_irq);
  assign l2_serr = low_lvl && lvl2_active && (trap_gen || (!host_mode && ovr_abort));

  // fast and normal interrupts: an interrupt seen at level 3 stays at level 3
  always_comb begin
    if ((lvl3_present && rt3_fiq) || at_l3) tgt_pfiq = 2'd3;
    else if (at_l2 || l2_fiq)               tgt_pfiq = 2'd2;
    else                                    tgt_pfiq = 2'd1;
  end

  always_comb begin
    if ((lvl3_present && rt3_irq) || at_l3) tgt_pirq = 2'd3;
    else if (at_l2 || l2_irq)               tgt_pirq = 2'd2;
    else                                    tgt_pirq = 2'd1;
  end

  always_comb begin
    if (at_l3 || (lvl3_present && rt3_abort)) tgt_pserr = 2'd3;
    else if (at_l2 || l2_serr)                tgt_pserr = 2'd2;
    else                                      tgt_pserr = 2'd1;
  end

  // virtual sources: guest context with level 2 enabled and no general trap
  assign guest_gate = low_lvl && lvl2_active && !trap_gen;
  assign ok_vserr   = guest_gate && ovr_abort;
  assign ok_vfiq    = guest_gate && ovr_fiq;
  assign ok_virq    = guest_gate && ovr_irq;
endmodule

// File: rtl/aer_select.sv
module aer_select #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/aer_synd.sv
module aer_synd
  import aer_pkg::*;
#(
  parameter bit HAS_RELIAB = 1'b1
) (
  input  kind_t            kind,
  input  logic             virt,
  input  logic             serr_flag,
  input  logic [SYN_W-1:0] serr_synd,
  input  logic             vsyn_flag,
  input  logic [SYN_W-1:0] vsyn_val,
  output logic [SYN_W:0]   synd
);
  always_comb begin
    synd = '0;
    if (kind == K_SERR) begin
      if (!virt) begin
        synd = {serr_flag, serr_synd};
      end else if (HAS_RELIAB) begin
        synd = {vsyn_flag, vsyn_val};
      end else begin
        synd = {serr_flag, (serr_flag ? serr_synd : {SYN_W{1'b0}})};
      end
    end
  end
endmodule

// File: rtl/async_exc_router.sv
module async_exc_router
  import aer_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter bit HAS_RELIAB = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pend_phys_serr,
  input  logic                 pend_phys_fiq,
  input  logic                 pend_phys_irq,
  input  logic                 pend_virt_serr,
  input  logic                 pend_virt_fiq,
  input  logic                 pend_virt_irq,
  input  logic [1:0]           cur_lvl,
  input  logic                 lvl3_present,
  input  logic                 lvl2_active,
  input  logic                 rt3_fiq,
  input  logic                 rt3_irq,
  input  logic                 rt3_abort,
  input  logic                 trap_gen,
  input  logic                 ovr_fiq,
  input  logic                 ovr_irq,
  input  logic                 ovr_abort,
  input  logic                 host_mode,
  input  logic                 serr_flag,
  input  logic [23:0]          serr_synd,
  input  logic                 vsyn_flag,
  input  logic [23:0]          vsyn_val,
  input  logic [ADDR_W-1:0]    cur_pc,
  output logic                 take_o,
  output logic [1:0]           tgt_lvl_o,
  output logic [11:0]          vec_off_o,
  output logic [1:0]           exc_kind_o,
  output logic                 virt_o,
  output logic [24:0]          synd_o,
  output logic [ADDR_W-1:0]    ret_addr_o,
  output logic                 clr_phys_serr_o,
  output logic                 clr_virt_serr_o
);
  localparam int DW = $bits(desc_t);

  logic [1:0]      tgt_pfiq, tgt_pirq, tgt_pserr;
  logic            ok_vserr, ok_vfiq, ok_virq;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic            any;
  desc_t           src_d [NSRC];
  logic [DW-1:0]   acc [NSRC+1];
  desc_t           sel;
  logic [SYN_W:0]  synd_n;

  aer_route u_route (
    .cur_lvl      (cur_lvl),
    .lvl3_present (lvl3_present),
    .lvl2_active  (lvl2_active),
    .rt3_fiq      (rt3_fiq),
    .rt3_irq      (rt3_irq),
    .rt3_abort    (rt3_abort),
    .trap_gen     (trap_gen),
    .ovr_fiq      (ovr_fiq),
    .ovr_irq      (ovr_irq),
    .ovr_abort    (ovr_abort),
    .host_mode    (host_mode),
    .tgt_pfiq     (tgt_pfiq),
    .tgt_pirq     (tgt_pirq),
    .tgt_pserr    (tgt_pserr),
    .ok_vserr     (ok_vserr),
    .ok_vfiq      (ok_vfiq),
    .ok_virq      (ok_virq)
  );

  // request vector in priority order, index 0 highest
  assign req[S_PSERR] = pend_phys_serr;
  assign req[S_PFIQ]  = pend_phys_fiq;
  assign req[S_PIRQ]  = pend_phys_irq;
  assign req[S_VSERR] = pend_virt_serr & ok_vserr;
  assign req[S_VFIQ]  = pend_virt_fiq  & ok_vfiq;
  assign req[S_VIRQ]  = pend_virt_irq  & ok_virq;

  assign src_d[S_PSERR] = '{kind: K_SERR, virt: 1'b0, tgt: tgt_pserr};
  assign src_d[S_PFIQ]  = '{kind: K_FIQ,  virt: 1'b0, tgt: tgt_pfiq};
  assign src_d[S_PIRQ]  = '{kind: K_IRQ,  virt: 1'b0, tgt: tgt_pirq};
  assign src_d[S_VSERR] = '{kind: K_SERR, virt: 1'b1, tgt: 2'd1};
  assign src_d[S_VFIQ]  = '{kind: K_FIQ,  virt: 1'b1, tgt: 2'd1};
  assign src_d[S_VIRQ]  = '{kind: K_IRQ,  virt: 1'b1, tgt: 2'd1};

  aer_select #(.N(NSRC)) u_sel (
    .req   (req),
    .grant (grant),
    .any   (any)
  );

  // one-hot AND-OR mux of the granted descriptor
  assign acc[0] = '0;
  for (genvar i = 0; i < NSRC; i++) begin : g_mux
    assign acc[i+1] = acc[i] | (grant[i] ? DW'(src_d[i]) : {DW{1'b0}});
  end
  assign sel = desc_t'(acc[NSRC]);

  aer_synd #(.HAS_RELIAB(HAS_RELIAB)) u_synd (
    .kind      (sel.kind),
    .virt      (sel.virt),
    .serr_flag (serr_flag),
    .serr_synd (serr_synd),
    .vsyn_flag (vsyn_flag),
    .vsyn_val  (vsyn_val),
    .synd      (synd_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o          <= 1'b0;
      tgt_lvl_o       <= '0;
      vec_off_o       <= '0;
      exc_kind_o      <= '0;
      virt_o          <= 1'b0;
      synd_o          <= '0;
      ret_addr_o      <= '0;
      clr_phys_serr_o <= 1'b0;
      clr_virt_serr_o <= 1'b0;
    end else begin
      take_o          <= any;
      tgt_lvl_o       <= sel.tgt;
      vec_off_o       <= vec_of(sel.kind);
      exc_kind_o      <= sel.kind;
      virt_o          <= sel.virt;
      synd_o          <= synd_n;
      ret_addr_o      <= any ? cur_pc : '0;
      clr_phys_serr_o <= grant[S_PSERR];
      clr_virt_serr_o <= grant[S_VSERR];
    end
  end
endmodule

// File: rtl/aer_checker.sv
module aer_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              pend_phys_serr,
  input logic [1:0]        cur_lvl,
  input logic [ADDR_W-1:0] cur_pc,
  input logic              take_o,
  input logic [1:0]        tgt_lvl_o,
  input logic [11:0]       vec_off_o,
  input logic [1:0]        exc_kind_o,
  input logic              virt_o,
  input logic [ADDR_W-1:0] ret_addr_o,
  input logic              clr_phys_serr_o,
  input logic              clr_virt_serr_o
);
  // R5: no level-2 delivery of a physical interrupt seen at level 3
  a_r5_no_l2_from_l3: assert property (@(posedge clk) disable iff (rst)
    (take_o && !virt_o && (exc_kind_o != 2'd3) && ($past(cur_lvl) == 2'd3))
      |-> (tgt_lvl_o == 2'd3));

  // R6: vector offset agrees with the reported kind
  a_r6_vec_kind: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((exc_kind_o == 2'd1 && vec_off_o == 12'h080) ||
                (exc_kind_o == 2'd2 && vec_off_o == 12'h100) ||
                (exc_kind_o == 2'd3 && vec_off_o == 12'h180)));

  // R8: virtual sources land at level 1
  a_r8_virt_l1: assert property (@(posedge clk) disable iff (rst)
    (take_o && virt_o) |-> (tgt_lvl_o == 2'd1));

  // R10: strobes accompany a matching take and are exclusive
  a_r10_clr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_phys_serr_o, clr_virt_serr_o}));

  a_r10_clr_match: assert property (@(posedge clk) disable iff (rst)
    (clr_phys_serr_o || clr_virt_serr_o) |->
      (take_o && exc_kind_o == 2'd3 && (virt_o == clr_virt_serr_o)));

  // R11: a pending physical system error wins over every other source
  a_r11_serr_first: assert property (@(posedge clk) disable iff (rst)
    (take_o && (virt_o || exc_kind_o != 2'd3)) |-> !$past(pend_phys_serr));

  // R12: return address is the instruction address of the request cycle
  a_r12_ret_addr: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (ret_addr_o == $past(cur_pc)));
endmodule

bind async_exc_router aer_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .pend_phys_serr  (pend_phys_serr),
  .cur_lvl         (cur_lvl),
  .cur_pc          (cur_pc),
  .take_o          (take_o),
  .tgt_lvl_o       (tgt_lvl_o),
  .vec_off_o       (vec_off_o),
  .exc_kind_o      (exc_kind_o),
  .virt_o          (virt_o),
  .ret_addr_o      (ret_addr_o),
  .clr_phys_serr_o (clr_phys_serr_o),
  .clr_virt_serr_o (clr_virt_serr_o)
);

// File: tb/async_exc_router_tb.sv
`timescale 1ns/1ps
module async_exc_router_tb;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p_serr, p_fiq, p_irq, v_serr, v_fiq, v_irq;
  logic [1:0] lvl;
  logic l3, l2, r3f, r3i, r3a, tge, of, oi, oa, hm;
  logic sflag, vflag;
  logic [23:0] ssyn, vval;
  logic [AW-1:0] pc;

  logic take, virt, cp, cv;
  logic [1:0] tgt, kind;
  logic [11:0] voff;
  logic [24:0] syn;
  logic [AW-1:0] ret;

  logic n_take, n_virt, n_cp, n_cv;
  logic [1:0] n_tgt, n_kind;
  logic [11:0] n_voff;
  logic [24:0] n_syn;
  logic [AW-1:0] n_ret;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  async_exc_router #(.ADDR_W(AW), .HAS_RELIAB(1'b1)) u_dut (
    .clk(clk), .rst(rst),
    .pend_phys_serr(p_serr), .pend_phys_fiq(p_fiq), .pend_phys_irq(p_irq),
    .pend_virt_serr(v_serr), .pend_virt_fiq(v_fiq), .pend_virt_irq(v_irq),
    .cur_lvl(lvl), .lvl3_present(l3), .lvl2_active(l2),
    .rt3_fiq(r3f), .rt3_irq(r3i), .rt3_abort(r3a),
    .trap_gen(tge), .ovr_fiq(of), .ovr_irq(oi), .ovr_abort(oa), .host_mode(hm),
    .serr_flag(sflag), .serr_synd(ssyn), .vsyn_flag(vflag), .vsyn_val(vval),
    .cur_pc(pc),
    .take_o(take), .tgt_lvl_o(tgt), .vec_off_o(voff), .exc_kind_o(kind),
    .virt_o(virt), .synd_o(syn), .ret_addr_o(ret),
    .clr_phys_serr_o(cp), .clr_virt_serr_o(cv)
  );

  async_exc_router #(.ADDR_W(AW), .HAS_RELIAB(1'b0)) u_dut_nr (
    .clk(clk), .rst(rst),
    .pend_phys_serr(p_serr), .pend_phys_fiq(p_fiq), .pend_phys_irq(p_irq),
    .pend_virt_serr(v_serr), .pend_virt_fiq(v_fiq), .pend_virt_irq(v_irq),
    .cur_lvl(lvl), .lvl3_present(l3), .lvl2_active(l2),
    .rt3_fiq(r3f), .rt3_irq(r3i), .rt3_abort(r3a),
    .trap_gen(tge), .ovr_fiq(of), .ovr_irq(oi), .ovr_abort(oa), .host_mode(hm),
    .serr_flag(sflag), .serr_synd(ssyn), .vsyn_flag(vflag), .vsyn_val(vval),
    .cur_pc(pc),
    .take_o(n_take), .tgt_lvl_o(n_tgt), .vec_off_o(n_voff), .exc_kind_o(n_kind),
    .virt_o(n_virt), .synd_o(n_syn), .ret_addr_o(n_ret),
    .clr_phys_serr_o(n_cp), .clr_virt_serr_o(n_cv)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    {p_serr, p_fiq, p_irq, v_serr, v_fiq, v_irq} = '0;
    lvl = 2'd0; l3 = 1'b1; l2 = 1'b1;
    {r3f, r3i, r3a, tge, of, oi, oa, hm} = '0;
    sflag = 1'b0; vflag = 1'b0; ssyn = '0; vval = '0;
    pc = 64'h0000_1000;
  endtask

  function automatic logic [11:0] off_for(input logic [1:0] k);
    case (k)
      2'd1: return 12'h080;
      2'd2: return 12'h100;
      2'd3: return 12'h180;
      default: return 12'h000;
    endcase
  endfunction

  // one request edge, then check the reported event
  task automatic expect_take(input string tag, input logic [1:0] etgt,
                             input logic [1:0] ekind, input logic evirt);
    step();
    chk({tag, " take"}, 64'(take), 64'd1);
    chk({tag, " tgt"},  64'(tgt),  64'(etgt));
    chk({tag, " kind"}, 64'(kind), 64'(ekind));
    chk({tag, " R6 voff"}, 64'(voff), 64'(off_for(ekind)));
    chk({tag, " R6 virt"}, 64'(virt), 64'(evirt));
  endtask

  task automatic t_reset();
    quiet();
    p_serr = 1'b1; p_fiq = 1'b1;
    step();
    chk("R1 take", 64'(take), 64'd0);
    chk("R1 clr", 64'({cp, cv}), 64'd0);
    chk("R1 syn/ret", 64'(syn) | ret, 64'd0);
    rst = 1'b0;
    quiet();
    step();
  endtask

  task automatic t_fiq();
    quiet(); p_fiq = 1'b1; r3f = 1'b1;
    expect_take("R2 route3", 2'd3, 2'd2, 1'b0);
    quiet(); p_fiq = 1'b1; r3f = 1'b1; l3 = 1'b0;
    expect_take("R2 no-l3", 2'd1, 2'd2, 1'b0);
    quiet(); p_fiq = 1'b1; lvl = 2'd2;
    expect_take("R2 at-l2", 2'd2, 2'd2, 1'b0);
    quiet(); p_fiq = 1'b1; lvl = 2'd1; of = 1'b1;
    expect_take("R2 ovr", 2'd2, 2'd2, 1'b0);
    quiet(); p_fiq = 1'b1; lvl = 2'd0; tge = 1'b1;
    expect_take("R2 trap", 2'd2, 2'd2, 1'b0);
    quiet(); p_fiq = 1'b1; lvl = 2'd1; of = 1'b1; l2 = 1'b0;
    expect_take("R2 l2-off", 2'd1, 2'd2, 1'b0);
    quiet(); p_fiq = 1'b1; lvl = 2'd1; oi = 1'b1; r3i = 1'b1;
    expect_take("R2 other-bits", 2'd1, 2'd2, 1'b0);
  endtask

  task automatic t_irq();
    quiet(); p_irq = 1'b1; r3i = 1'b1;
    expect_take("R3 route3", 2'd3, 2'd1, 1'b0);
    quiet(); p_irq = 1'b1; lvl = 2'd1; oi = 1'b1;
    expect_take("R3 ovr", 2'd2, 2'd1, 1'b0);
    quiet(); p_irq = 1'b1; lvl = 2'd1; of = 1'b1; r3f = 1'b1;
    expect_take("R3 fiq-bits", 2'd1, 2'd1, 1'b0);
    chk("R7 irq syn", 64'(syn), 64'd0);
  endtask

  task automatic t_serr();
    quiet(); p_serr = 1'b1; lvl = 2'd3;
    sflag = 1'b1; ssyn = 24'hA5_C3_0F;
    expect_take("R4 at-l3", 2'd3, 2'd3, 1'b0);
    chk("R7 syn", 64'(syn), 64'({1'b1, 24'hA5_C3_0F}));
    chk("R10 clr phys", 64'({cp, cv}), 64'b10);
    quiet(); p_serr = 1'b1; r3a = 1'b1;
    expect_take("R4 route3", 2'd3, 2'd3, 1'b0);
    quiet(); p_serr = 1'b1; lvl = 2'd1; oa = 1'b1; ssyn = 24'h12_3456;
    expect_take("R4 ovr", 2'd2, 2'd3, 1'b0);
    chk("R7 syn flag0", 64'(syn), 64'({1'b0, 24'h12_3456}));
    quiet(); p_serr = 1'b1; lvl = 2'd1; oa = 1'b1; hm = 1'b1;
    expect_take("R4 host", 2'd1, 2'd3, 1'b0);
    quiet(); p_serr = 1'b1; lvl = 2'd0; tge = 1'b1; hm = 1'b1;
    expect_take("R4 host-trap", 2'd2, 2'd3, 1'b0);
    quiet(); p_serr = 1'b1; lvl = 2'd2;
    expect_take("R4 at-l2", 2'd2, 2'd3, 1'b0);
  endtask

  task automatic t_level3();
    quiet(); p_fiq = 1'b1; lvl = 2'd3; tge = 1'b1; of = 1'b1;
    expect_take("R5 fiq", 2'd3, 2'd2, 1'b0);
    quiet(); p_irq = 1'b1; lvl = 2'd3; oi = 1'b1;
    expect_take("R5 irq", 2'd3, 2'd1, 1'b0);
  endtask

  task automatic t_virt();
    quiet(); v_fiq = 1'b1; lvl = 2'd1; of = 1'b1;
    expect_take("R8 vfiq", 2'd1, 2'd2, 1'b1);
    quiet(); v_irq = 1'b1; lvl = 2'd0; oi = 1'b1;
    expect_take("R8 virq", 2'd1, 2'd1, 1'b1);
    quiet(); v_fiq = 1'b1; lvl = 2'd1; of = 1'b1; tge = 1'b1;
    step();
    chk("R8 trap ignored", 64'(take), 64'd0);
    quiet(); v_serr = 1'b1; lvl = 2'd2; oa = 1'b1;
    step();
    chk("R8 level ignored", 64'({take, cp, cv}), 64'd0);
    quiet(); v_irq = 1'b1; lvl = 2'd1; of = 1'b1;
    step();
    chk("R8 wrong-ovr ignored", 64'(take), 64'd0);
    quiet(); v_fiq = 1'b1; lvl = 2'd1; of = 1'b1; l2 = 1'b0;
    step();
    chk("R8 l2-off ignored", 64'(take), 64'd0);
  endtask

  task automatic t_vserr();
    quiet(); v_serr = 1'b1; lvl = 2'd1; oa = 1'b1;
    vflag = 1'b1; vval = 24'h0B_EE_F0; sflag = 1'b0; ssyn = 24'h77_7777;
    expect_take("R9 vserr", 2'd1, 2'd3, 1'b1);
    chk("R9 syn reg", 64'(syn), 64'({1'b1, 24'h0B_EE_F0}));
    chk("R10 clr virt", 64'({cp, cv}), 64'b01);
    chk("R9 nr flag0", 64'(n_syn), 64'd0);
    chk("R10 nr clr", 64'({n_take, n_cp, n_cv}), 64'b101);
    quiet(); v_serr = 1'b1; lvl = 2'd0; oa = 1'b1;
    sflag = 1'b1; ssyn = 24'hC0_FFEE; vflag = 1'b0; vval = 24'h11_1111;
    step();
    chk("R9 syn reg2", 64'(syn), 64'({1'b0, 24'h11_1111}));
    chk("R9 nr flag1", 64'(n_syn), 64'({1'b1, 24'hC0_FFEE}));
  endtask

  task automatic t_prio();
    quiet();
    {p_serr, p_fiq, p_irq, v_serr, v_fiq, v_irq} = 6'h3F;
    lvl = 2'd1; of = 1'b1; oi = 1'b1; oa = 1'b1;
    expect_take("R11 pserr", 2'd2, 2'd3, 1'b0);
    p_serr = 1'b0;
    expect_take("R11 pfiq", 2'd2, 2'd2, 1'b0);
    chk("R11 no clr", 64'({cp, cv}), 64'd0);
    p_fiq = 1'b0;
    expect_take("R11 pirq", 2'd2, 2'd1, 1'b0);
    p_irq = 1'b0;
    expect_take("R11 vserr", 2'd1, 2'd3, 1'b1);
    v_serr = 1'b0;
    expect_take("R11 vfiq", 2'd1, 2'd2, 1'b1);
    v_fiq = 1'b0;
    expect_take("R11 virq", 2'd1, 2'd1, 1'b1);
    oi = 1'b0; p_irq = 1'b1; v_fiq = 1'b1; of = 1'b0; v_serr = 1'b1;
    expect_take("R11 skip-ineligible", 2'd1, 2'd1, 1'b0);
  endtask

  task automatic t_timing();
    quiet(); p_irq = 1'b1; pc = 64'hFFFF_0000_DEAD_BEE0;
    step();
    chk("R12 take", 64'(take), 64'd1);
    chk("R12 ret", ret, 64'hFFFF_0000_DEAD_BEE0);
    p_irq = 1'b0; pc = 64'h0000_0000_0000_4444;
    step();
    chk("R12 drop", 64'(take), 64'd0);
    chk("R12 no clr", 64'({cp, cv}), 64'd0);
  endtask

  initial begin
    quiet();
    rst = 1'b1;
    step();
    t_reset();
    t_fiq();
    t_irq();
    t_serr();
    t_level3();
    t_virt();
    t_vserr();
    t_prio();
    t_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule